// File: doc/BRIEF.md
# Configurable-Trigger Interrupt Aggregator

This block merges a bank of peripheral interrupt lines into one request for a parent interrupt controller. Each line first crosses a two-flop synchronizer. It is then judged by its own trigger mode, which is one of level-high, level-low, rising edge or falling edge. Qualifying events are kept in a per-line status vector. The parent request is asserted whenever any status bit is pending on a line that software has enabled.

Software works through a small word-addressed register port with valid/ready handshaking. Through it, software can program enables, trigger polarity and trigger kind, raise any line by hand, and acknowledge lines. Edge events are held until they are acknowledged. Level lines show their active level directly, so an acknowledge of a level line that is still active has no lasting effect. After reset every line is masked and configured as level-high.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the enable register reads 0x0000_0000, the status register reads 0x0000_0000, the edge-select register reads 0x0000_0000, the polarity register reads 0xFFFF_FFFF, and the request output is low.
- R2: The registers sit at fixed byte offsets: status 0x00, enable 0x04, set 0x08, clear 0x0C, polarity 0x10, edge-select 0x14. Status is read-only, so writes to it are ignored. Set and clear read as zero. Any other offset, including a misaligned one, reads zero and ignores writes.
- R3: With its edge-select bit at 0, a line is level triggered. Polarity 1 means active high and polarity 0 means active low. The line's status bit shows the active level two clock edges after the input changes.
- R4: With its edge-select bit at 1, a line is edge triggered. Polarity 1 selects the rising edge and polarity 0 selects the falling edge. The status bit becomes 1 three clock edges after the selected edge and stays 1 until it is cleared. The opposite edge does nothing.
- R5: Writing 1s to the clear register acknowledges the latched events of those lines. A level line that is still at its active level keeps reading 1.
- R6: Writing 1s to the set register makes those status bits 1. The forced bit stays 1 until it is cleared, whatever the line's input does.
- R7: The request output is high exactly when at least one line has both its status bit and its enable bit at 1. With enable at zero, the output stays low.
- R8: An edge event that qualifies at the same clock edge as a clear write to that line is kept latched.
- R9: The port always accepts a request (ready is always high). A read returns its data on the following cycle, with response-valid high for that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 32 | Raw peripheral interrupt lines |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq_out | output | 1 | Aggregated request to the parent controller |

## Verification
Each trigger mode is driven with a line held active, then released, then pulsed. This separates level-following from latching, and it shows whether the opposite edge is wrongly accepted. Clear writes are placed at several cycle offsets around an incoming edge, which exposes whether the latch or the acknowledge wins. Fixed scenarios with set, clear, masked and unmapped accesses are followed by a long random mix of input toggles and register traffic. A behavioural model built on an input history queue predicts the request output and every read, and the bench compares it with the design on every clock.

// File: rtl/irq_aggregator.sv
`timescale 1ns/1ps
module irq_aggregator #(
  parameter int LINES  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_in,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LINES-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic [LINES-1:0]  rsp_rdata,
  output logic              irq_out
);
  localparam int SW = ADDR_W - 2;
  localparam logic [SW-1:0] SEL_STAT = SW'(0);
  localparam logic [SW-1:0] SEL_EN   = SW'(1);
  localparam logic [SW-1:0] SEL_SET  = SW'(2);
  localparam logic [SW-1:0] SEL_CLR  = SW'(3);
  localparam logic [SW-1:0] SEL_POL  = SW'(4);
  localparam logic [SW-1:0] SEL_EDG  = SW'(5);

  logic [LINES-1:0] sync1, sync2, prev, latch, en, pol, edg;
  logic [LINES-1:0] rise, fall, hit, lvl_act, stat, set_v, clr_v, rd_mux;
  logic [SW-1:0]    sel;
  logic             aligned, wr, rd;

  assign req_ready = 1'b1;
  assign sel       = req_addr[ADDR_W-1:2];
  assign aligned   = (req_addr[1:0] == 2'b00);
  assign wr        = req_valid & req_write & aligned;
  assign rd        = req_valid & ~req_write;

  assign rise    = sync2 & ~prev;
  assign fall    = ~sync2 & prev;
  assign hit     = edg & ((pol & rise) | (~pol & fall));
  assign lvl_act = ~edg & ~(sync2 ^ pol);
  assign stat    = latch | lvl_act;

  assign set_v = (wr && sel == SEL_SET) ? req_wdata : '0;
  assign clr_v = (wr && sel == SEL_CLR) ? req_wdata : '0;

  assign irq_out = |(stat & en);

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      case (sel)
        SEL_STAT: rd_mux = stat;
        SEL_EN:   rd_mux = en;
        SEL_POL:  rd_mux = pol;
        SEL_EDG:  rd_mux = edg;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
      latch <= '0;
      en    <= '0;
      pol   <= '1;
      edg   <= '0;
    end else begin
      sync1 <= irq_in;
      sync2 <= sync1;
      prev  <= sync2;
      latch <= ((latch | set_v) & ~clr_v) | hit;
      if (wr && sel == SEL_EN)  en  <= req_wdata;
      if (wr && sel == SEL_POL) pol <= req_wdata;
      if (wr && sel == SEL_EDG) edg <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      rsp_rdata <= rd ? rd_mux : '0;
    end
  end

  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid); // R9
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq_out); // R7
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((latch & ~clr_v) != '0) |=> ((latch & $past(latch & ~clr_v)) == $past(latch & ~clr_v))); // R4
  AST_CLEAR_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_v & ~hit) != '0) |=> ((latch & $past(clr_v & ~hit)) == '0)); // R5
  AST_SET_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_v & ~clr_v) != '0) |=> ((stat & $past(set_v & ~clr_v)) == $past(set_v & ~clr_v))); // R6
  AST_SETCLR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && aligned && (sel == SEL_SET || sel == SEL_CLR)) |=> (rsp_rdata == '0)); // R2
endmodule

// File: tb/irq_aggregator_test.sv
`timescale 1ns/1ps
module irq_aggregator_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq_out;
  logic [31:0] rsp_rdata;

  irq_aggregator uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_out(irq_out)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  logic [31:0] hist[$];
  logic [31:0] m_latch, m_en, m_pol, m_edg;
  bit          exp_rvalid;
  logic [31:0] exp_rdata;
  string       cur_tag = "R2", exp_tag = "R2";

  function automatic logic [31:0] m_stat(logic [31:0] lvl);
    return m_latch | (~m_edg & ~(lvl ^ m_pol));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{32'h0, 32'h0, 32'h0, 32'h0};
      m_latch = '0; m_en = '0; m_pol = '1; m_edg = '0;
      exp_rvalid = 0; exp_rdata = '0;
    end else begin
      automatic logic [31:0] lv = hist[hist.size()-2];
      automatic logic [31:0] pv = hist[hist.size()-3];
      automatic logic [31:0] ev = '0, setv = '0, clrv = '0;
      automatic int a = int'(req_addr);
      for (int i = 0; i < 32; i++)
        if (m_edg[i] && ((m_pol[i] && lv[i] && !pv[i]) || (!m_pol[i] && !lv[i] && pv[i])))
          ev[i] = 1'b1;
      exp_rvalid = req_valid && !req_write;
      exp_tag = cur_tag;
      exp_rdata = '0;
      if (exp_rvalid) begin
        if (a == 0) exp_rdata = m_stat(lv);
        else if (a == 4) exp_rdata = m_en;
        else if (a == 16) exp_rdata = m_pol;
        else if (a == 20) exp_rdata = m_edg;
      end
      if (req_valid && req_write) begin
        if (a == 8)  setv = req_wdata;
        if (a == 12) clrv = req_wdata;
        if (a == 4)  m_en = req_wdata;
        if (a == 16) m_pol = req_wdata;
        if (a == 20) m_edg = req_wdata;
      end
      m_latch = ((m_latch | setv) & ~clrv) | ev;
      hist.push_back(irq_in);
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R7 irq_out", {31'b0, irq_out}, {31'b0, |(m_stat(hist[hist.size()-2]) & m_en)});
      chk("R9 ready", {31'b0, req_ready}, 32'd1);
      chk("R9 rsp_valid", {31'b0, rsp_valid}, {31'b0, exp_rvalid});
      if (exp_rvalid) chk(exp_tag, rsp_rdata, exp_rdata);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(logic [4:0] a, string tag);
    cur_tag = tag;
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    chk("R1 irq after reset", {31'b0, irq_out}, 32'd0);
    rd(5'h00, "R1 status reset"); rd(5'h04, "R1 enable reset");
    rd(5'h10, "R1 polarity reset"); rd(5'h14, "R1 edge reset");
    idle(2);
    wr(5'h04, 32'hFFFF_FFFF);
    irq_in[0] = 1; idle(1); rd(5'h00, "R3 level-high early"); idle(3);
    rd(5'h00, "R3 level-high active");
    irq_in[0] = 0; idle(4); rd(5'h00, "R3 level-high released");
    wr(5'h10, 32'hFFFF_FFFD); idle(3); rd(5'h00, "R3 level-low idle input");
    irq_in[1] = 1; idle(4); rd(5'h00, "R3 level-low inactive");
    wr(5'h14, 32'h0000_000C); wr(5'h10, 32'hFFFF_FFF7);
    irq_in[2] = 1; idle(2); irq_in[2] = 0; idle(4);
    rd(5'h00, "R4 rising latched"); idle(5); rd(5'h00, "R4 rising held");
    wr(5'h0C, 32'h0000_0004); idle(1); rd(5'h00, "R5 edge acknowledged");
    irq_in[3] = 1; idle(5); rd(5'h00, "R4 falling ignores rise");
    irq_in[3] = 0; idle(5); rd(5'h00, "R4 falling latched");
    wr(5'h0C, 32'h0000_0008);
    irq_in[0] = 1; idle(4); wr(5'h0C, 32'h0000_0001); rd(5'h00, "R5 level still active");
    irq_in[0] = 0; idle(4);
    wr(5'h08, 32'h0000_0020); idle(4); rd(5'h00, "R6 set forced");
    irq_in[5] = 1; idle(3); irq_in[5] = 0; idle(4); rd(5'h00, "R6 set persists");
    wr(5'h0C, 32'h0000_0020); rd(5'h00, "R6 cleared");
    wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, "R2 status write ignored");
    rd(5'h08, "R2 set reads zero"); rd(5'h0C, "R2 clear reads zero");
    rd(5'h18, "R2 unmapped reads zero"); rd(5'h05, "R2 misaligned reads zero");
    wr(5'h06, 32'h0); rd(5'h04, "R2 misaligned write ignored");
    wr(5'h08, 32'h0000_0100); wr(5'h04, 32'h0); idle(2);
    chk("R7 masked output", {31'b0, irq_out}, 32'd0);
    wr(5'h0C, 32'hFFFF_FFFF); wr(5'h04, 32'hFFFF_FFFF);
    for (int d = 0; d < 5; d++) begin
      irq_in[2] = 1;
      idle(d);
      wr(5'h0C, 32'h0000_0004);
      idle(4);
      rd(5'h00, "R8 edge vs clear");
      irq_in[2] = 0;
      idle(4);
      wr(5'h0C, 32'h0000_0004);
    end
    for (int n = 0; n < 4000; n++) begin
      case ($urandom_range(0, 5))
        0: irq_in = irq_in ^ (32'h1 << $urandom_range(0, 31));
        1: wr(5'($urandom_range(0, 31)), $urandom());
        2: rd(5'($urandom_range(0, 31)), "R4 random read");
        3: wr(5'h0C, $urandom());
        4: irq_in = $urandom();
        default: idle(1);
      endcase
      idle(1);
    end
    idle(4);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule